// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block collects the event and condition flags of a card host interface into one 32-bit status word. It qualifies that word with a mask and drives a single interrupt line to the processor. Ready and busy conditions arrive as live levels and are shown as they are. Error conditions arrive as one-cycle pulses and are held until software reads the status word.

The mask cannot be written directly. One write port sets mask bits wherever the written data has a one. A second write port clears mask bits wherever the written data has a one. Software can therefore change one source without a read-modify-write. The processor reaches the block over a plain register bus made of an address, a write strobe, a read strobe, write data and combinational read data.

The offsets are fixed. The status word is read at 0x40, the set port is at 0x44, the clear port is at 0x48 and the mask reads back at 0x4C. All nine error flags are also combined into one aggregate error output.

Top module: `ism_top`

## Requirements
- R1: After reset the mask is all zeros, no error flag is held, and `irq` and `err_any` are low.
- R2: A write to offset 0x44 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x48 clears every mask bit whose write-data bit is 1. Writing 0xFFFFFFFF there masks every source.
- R4: A read at 0x40 returns the status word and a read at 0x4C returns the mask. Any other offset reads as zero. Writes to 0x40 and to 0x4C change nothing.
- R5: Status bits 0–7, 14 and 15 copy `lvl_in` one clock later. `lvl_in` bits at other positions are ignored.
- R6: Status bits 16–22, 30 and 31 are error flags. A 1 on the matching `err_in` bit sets the flag, and the flag then stays set. `err_in` bits at other positions are ignored.
- R7: A read of 0x40 with `bus_rd` high returns the flags and clears every error flag at the next clock. An error pulse arriving in that same cycle is kept set.
- R8: `irq` is a registered OR of (status AND mask). It changes one clock after a status input change or a mask write.
- R9: `err_any` is high exactly when at least one of the nine error flags is set.
- R10: Status bits 8–13 and 23–29 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the error flags when the status word is read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| lvl_in | input | 32 | Live ready and busy levels |
| err_in | input | 32 | Error event pulses |
| irq | output | 1 | Interrupt request |
| err_any | output | 1 | Aggregate error flag |

## Verification
The bench checks that zeros in a set or clear write leave the other mask bits alone. A design that treated either port as a plain store would wipe out neighbouring enables. It checks that error flags outlive their pulse and drop only after a status read. It also sends a pulse in the same cycle as the clearing read, which a design with clear priority would lose. Stimulus on reserved, level-only and error-only positions of the wrong input shows whether a design leaks bits across the groups. `irq` is sampled exactly one cycle after each cause, so an extra pipeline stage shows up as a late edge.

// File: rtl/ism_pkg.sv
package ism_pkg;

    localparam int DW = 32;
    typedef logic [DW-1:0] word_t;

    // status bit positions
    localparam int B_CMD_RDY  = 0;
    localparam int B_RX_RDY   = 1;
    localparam int B_TX_RDY   = 2;
    localparam int B_BLK_END  = 3;
    localparam int B_XFER_ON  = 4;
    localparam int B_NOT_BUSY = 5;
    localparam int B_RX_END   = 6;
    localparam int B_TX_END   = 7;
    localparam int B_RX_FULL  = 14;
    localparam int B_TX_EMPTY = 15;
    localparam int B_RSP_IDX  = 16;
    localparam int B_RSP_DIR  = 17;
    localparam int B_RSP_CRC  = 18;
    localparam int B_RSP_END  = 19;
    localparam int B_RSP_TMO  = 20;
    localparam int B_DAT_CRC  = 21;
    localparam int B_DAT_TMO  = 22;
    localparam int B_OVERRUN  = 30;
    localparam int B_UNDERRUN = 31;

    // register offsets
    localparam int OFF_STATUS = 'h40;
    localparam int OFF_MSET   = 'h44;
    localparam int OFF_MCLR   = 'h48;
    localparam int OFF_MASK   = 'h4C;

    function automatic word_t bit_of(input int pos);
        word_t v;
        v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    localparam word_t LVL_MASK =
        bit_of(B_CMD_RDY) | bit_of(B_RX_RDY) | bit_of(B_TX_RDY) |
        bit_of(B_BLK_END) | bit_of(B_XFER_ON) | bit_of(B_NOT_BUSY) |
        bit_of(B_RX_END) | bit_of(B_TX_END) | bit_of(B_RX_FULL) |
        bit_of(B_TX_EMPTY);

    localparam word_t ERR_MASK =
        bit_of(B_RSP_IDX) | bit_of(B_RSP_DIR) | bit_of(B_RSP_CRC) |
        bit_of(B_RSP_END) | bit_of(B_RSP_TMO) | bit_of(B_DAT_CRC) |
        bit_of(B_DAT_TMO) | bit_of(B_OVERRUN) | bit_of(B_UNDERRUN);

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STATUS,
        REG_MSET,
        REG_MCLR,
        REG_MREAD
    } reg_sel_e;

    typedef struct packed {
        logic  set_en;
        logic  clr_en;
        word_t bits;
    } mask_cmd_t;

endpackage

// File: rtl/ism_decode.sv
module ism_decode
    import ism_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  word_t             bus_wdata,
    output reg_sel_e          sel,
    output mask_cmd_t         mcmd,
    output logic              rd_clr
);
    always_comb begin
        if (bus_addr == ADDR_W'(OFF_STATUS))      sel = REG_STATUS;
        else if (bus_addr == ADDR_W'(OFF_MSET))   sel = REG_MSET;
        else if (bus_addr == ADDR_W'(OFF_MCLR))   sel = REG_MCLR;
        else if (bus_addr == ADDR_W'(OFF_MASK))   sel = REG_MREAD;
        else                                      sel = REG_NONE;
    end

    always_comb begin
        mcmd.set_en = bus_wr && (sel == REG_MSET);
        mcmd.clr_en = bus_wr && (sel == REG_MCLR);
        mcmd.bits   = bus_wdata;
    end

    assign rd_clr = bus_rd && (sel == REG_STATUS);

endmodule

// File: rtl/ism_status.sv
module ism_status
    import ism_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t lvl_in,
    input  word_t err_in,
    input  logic  rd_clr,
    output word_t status_q,
    output word_t status_d
);
    word_t held_err;

    always_comb begin
        held_err = status_q & ERR_MASK;
        if (rd_clr) held_err = '0;
        status_d = (lvl_in & LVL_MASK) | held_err | (err_in & ERR_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    // error flags never drop without a clearing read
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> ((status_q & $past(status_q) & ERR_MASK) ==
                     ($past(status_q) & ERR_MASK)));

    // after a clearing read only same-cycle pulses survive
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> ((status_q & ERR_MASK) == ($past(err_in) & ERR_MASK)));

endmodule

// File: rtl/ism_mask.sv
module ism_mask
    import ism_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mask_cmd_t mcmd,
    output word_t     mask_q,
    output word_t     mask_d
);
    always_comb begin
        mask_d = mask_q;
        if (mcmd.set_en) mask_d = mask_d | mcmd.bits;
        if (mcmd.clr_en) mask_d = mask_d & ~mcmd.bits;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        mcmd.set_en |=> ((mask_q & $past(mcmd.bits)) == $past(mcmd.bits)));

    p_clr_r3: assert property (@(posedge clk) disable iff (rst)
        mcmd.clr_en |=> ((mask_q & $past(mcmd.bits)) == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mcmd.set_en && !mcmd.clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/ism_irq.sv
module ism_irq
    import ism_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t status_d,
    input  word_t mask_d,
    output logic  irq
);
    word_t cause;

    assign cause = status_d & mask_d;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |cause;
    end

endmodule

// File: rtl/ism_top.sv
module ism_top
    import ism_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       lvl_in,
    input  logic [31:0]       err_in,
    output logic              irq,
    output logic              err_any
);
    reg_sel_e  sel;
    mask_cmd_t mcmd;
    logic      rd_clr;
    word_t     status_q, status_d, mask_q, mask_d;

    ism_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .sel      (sel),
        .mcmd     (mcmd),
        .rd_clr   (rd_clr)
    );

    ism_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .lvl_in  (lvl_in),
        .err_in  (err_in),
        .rd_clr  (rd_clr),
        .status_q(status_q),
        .status_d(status_d)
    );

    ism_mask u_mask (
        .clk   (clk),
        .rst   (rst),
        .mcmd  (mcmd),
        .mask_q(mask_q),
        .mask_d(mask_d)
    );

    ism_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .status_d(status_d),
        .mask_d  (mask_d),
        .irq     (irq)
    );

    always_comb begin
        case (sel)
            REG_STATUS: bus_rdata = status_q;
            REG_MREAD:  bus_rdata = mask_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign err_any = |(status_q & ERR_MASK);

    // interrupt agrees with the registered status and mask
    p_irq_r8: assert property (@(posedge clk) disable iff (rst)
        irq == |(status_q & mask_q));

    // a clearing read leaves only same-cycle error pulses
    p_rdclr_r7: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (!err_any || (($past(err_in) & ERR_MASK) != '0)));

    // reserved positions never show up
    p_rsv_r10: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~(LVL_MASK | ERR_MASK)) == '0);

endmodule

// File: tb/test_ism_top.sv
module test_ism_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] lvl_in = '0;
    logic [31:0] err_in = '0;
    logic        irq, err_any;

    always #5 clk = ~clk;

    ism_top #(.ADDR_W(8)) i_ism_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lvl_in(lvl_in), .err_in(err_in), .irq(irq), .err_any(err_any)
    );

    typedef struct {
        int          what;   // 0 rdata, 1 irq, 2 err_any
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    // monitor: pops expected items and compares with the ports
    initial forever begin
        item_t it;
        logic [31:0] act;
        wait (q.size() != 0);
        it = q.pop_front();
        case (it.what)
            0: act = bus_rdata;
            1: act = {31'b0, irq};
            default: act = {31'b0, err_any};
        endcase
        n_run++;
        if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
    end

    task automatic expect_port(input int what, input logic [31:0] exp, input string tag);
        item_t it;
        #1;
        it.what = what; it.exp = exp; it.tag = tag;
        q.push_back(it);
        #0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input bit clr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = clr;
        expect_port(0, exp, tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_lvl(input logic [31:0] v);
        @(negedge clk);
        lvl_in = v;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        err_in = v;
        @(negedge clk);
        err_in = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        rd(8'h4C, 0, 32'h0, "R1 mask after reset");
        rd(8'h40, 0, 32'h0, "R1 status after reset");
        expect_port(1, 0, "R1 irq after reset");
        expect_port(2, 0, "R1 err_any after reset");
        // R2 set port
        wr(8'h44, 32'h0000_8001);
        wr(8'h44, 32'h0000_0004);
        rd(8'h4C, 0, 32'h0000_8005, "R2 set keeps other bits");
        // R3 clear port
        wr(8'h48, 32'h0000_0001);
        rd(8'h4C, 0, 32'h0000_8004, "R3 clear one bit");
        // R5 level inputs, R10 reserved, R8 timing
        set_lvl(32'hFFFF_FFFF);
        expect_port(1, 1, "R8 irq one cycle after level rise");
        expect_port(2, 0, "R9 levels are not errors");
        rd(8'h40, 0, 32'h0000_C0FF, "R5 R10 level bits only");
        set_lvl(32'h0);
        expect_port(1, 0, "R8 irq drops with level");
        wr(8'h48, 32'hFFFF_FFFF);
        rd(8'h4C, 0, 32'h0, "R3 all ones masks everything");
        // R6 sticky errors
        pulse(32'hFFFF_FFFF);
        expect_port(2, 1, "R9 err_any after pulse");
        expect_port(1, 0, "R8 masked error gives no irq");
        repeat (3) @(negedge clk);
        rd(8'h40, 0, 32'hC07F_0000, "R6 errors stay after pulse");
        wr(8'h44, 32'h0010_0000);
        expect_port(1, 1, "R8 irq one cycle after mask write");
        // R4 ignored writes and unused offsets
        wr(8'h40, 32'h0);
        rd(8'h40, 0, 32'hC07F_0000, "R4 status write ignored");
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h4C, 0, 32'h0010_0000, "R4 mask readback write ignored");
        rd(8'h44, 0, 32'h0, "R4 set port reads zero");
        rd(8'h48, 0, 32'h0, "R4 clear port reads zero");
        rd(8'h10, 0, 32'h0, "R4 unused offset reads zero");
        // R7 clear on read
        rd(8'h40, 1, 32'hC07F_0000, "R7 read returns flags");
        expect_port(2, 0, "R7 err_any after clearing read");
        expect_port(1, 0, "R7 irq after clearing read");
        rd(8'h40, 0, 32'h0, "R7 status cleared");
        // R7 pulse during clearing read survives
        @(negedge clk);
        bus_addr = 8'h40; bus_rd = 1'b1; err_in = 32'h0020_0000;
        @(negedge clk);
        bus_rd = 1'b0; err_in = '0;
        rd(8'h40, 0, 32'h0020_0000, "R7 same-cycle pulse kept");
        expect_port(2, 1, "R9 err_any for kept pulse");
        pulse(32'h0010_0000);
        expect_port(1, 1, "R8 unmasked error raises irq");
        rd(8'h40, 1, 32'h0030_0000, "R6 two errors accumulate");
        expect_port(1, 0, "R7 irq cleared by read");
        // R6 non-error positions of err_in ignored
        pulse(32'h3F80_FFFF);
        rd(8'h40, 0, 32'h0, "R6 err_in non-error bits ignored");
        expect_port(2, 0, "R9 no error from ignored bits");
        // R5 non-level positions of lvl_in ignored
        set_lvl(32'hFFFF_3F00);
        rd(8'h40, 0, 32'h0, "R5 lvl_in other bits ignored");
        wr(8'h44, 32'h0000_0020);
        set_lvl(32'h0000_0020);
        expect_port(1, 1, "R8 not-busy level raises irq");
        rd(8'h40, 0, 32'h0000_0020, "R5 not-busy bit 5");
        wait (q.size() == 0);
        #1;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule